// File: doc/BRIEF.md
# Test Access Port with FPGA Reconfiguration Control

This block is the boundary-scan test access port of a configuration-memory device. A host walks the standard sixteen-state controller with TMS and moves data through TDI and TDO. It can read back a fixed identification word and a 32-bit user word. It can sample or drive the device pins through a boundary chain whose length is a parameter. It can also bypass the device with a single-bit register.

Two extra instructions control an active-low, open-drain output that is wired to the configuration-start pin of an FPGA. The first one pulls that pin low only while the controller rests in Run-Test/Idle, so the FPGA restarts its configuration when the controller moves on. The second one pulls the pin low and keeps it low across later instructions, until the pulse instruction becomes current or the controller enters Test-Logic-Reset. The output is modelled as a pull-down enable: when it is high the pin is pulled low, and when it is low the pin is released. The pin is never driven high.

The user word is written through a parallel load port that is clocked by TCK. The pin interface is a generic capture bus and a generic update bus. The block does not contain the pad drivers.

Top module: `cfg_tap`

## Requirements
- R1: The controller follows the sixteen-state test-access state machine. Five rising TCK edges with TMS=1 reach Test-Logic-Reset from any state. `tap_rst` high at a rising edge forces that state, clears the held pull-down and sets `pin_out` to zero. After reset, `tdo_oe`, `recfg_low` and `pin_drive` are 0.
- R2: The instruction register is 10 bits wide. In Capture-IR it loads 10'b00_0000_0001, and bit 0 leaves first on TDO. In Test-Logic-Reset it loads the identification opcode, so a data scan with no prior instruction scan returns the identification word.
- R3: The opcodes are: identify = 0x059, user word = 0x079, sample/preload = 0x055, external test = 0x000, bypass = 0x3FF, pulse-reconfigure = 0x061, hold-reconfigure = 0x065. Every other opcode, and both reconfiguration opcodes, select the 1-bit bypass register. The bypass register captures 0, so the output of an n-bit data scan is 0 followed by the first n-1 input bits.
- R4: The identification data register captures 0x0100A0DD and shifts it out LSB first.
- R5: When `ucode_load` is high at a rising TCK edge, the user word takes `ucode_value`. Its reset value is the parameter `UCODE_INIT`. The user-word instruction shifts the word out LSB first. Shifting does not change the stored word.
- R6: Under sample/preload or external test, the boundary chain of `BSC_LEN` cells captures `pin_in` in Capture-DR, with cell 0 leaving first. In Update-DR it copies the chain to `pin_out`. At all other times `pin_out` holds its value.
- R7: `pin_drive` is high exactly while external test is the current instruction.
- R8: TDO and `tdo_oe` change only on falling TCK edges. `tdo_oe` is high only in Shift-DR and Shift-IR.
- R9: While pulse-reconfigure is the current instruction, `recfg_low` is high in Run-Test/Idle and low in every other state.
- R10: From the edge that makes hold-reconfigure current, `recfg_low` stays high through later instructions. It is released only when pulse-reconfigure becomes current or Test-Logic-Reset is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO output enable |
| ucode_load | input | 1 | Load strobe for the user word |
| ucode_value | input | 32 | New user word |
| pin_in | input | BSC_LEN | Pin states captured by the boundary chain |
| pin_out | output | BSC_LEN | Boundary update stage, the pattern for the pins |
| pin_drive | output | 1 | Boundary pattern drives the pins (external test) |
| recfg_low | output | 1 | Pull the FPGA configuration-start pin low |

## Verification
Each serial bit appears on TDO after the falling edge that follows the rising edge which shifted it. The bench therefore drives TMS and TDI at that falling edge and reads TDO 1 ns later. It also confirms that TDO has not moved 0.5 ns after the next rising edge. A new instruction, and its effect on `recfg_low` and `pin_drive`, takes hold at the rising edge that leaves Update-IR. `pin_out` changes at the rising edge that leaves Update-DR. The bench samples these outputs at the next falling edge, while the controller still rests in Run-Test/Idle, or during the first Shift-DR bit when a value outside the idle state is needed.

// File: rtl/cfg_tap_pkg.sv
`timescale 1ns/1ps
package cfg_tap_pkg;

    localparam int IR_W   = 10;
    localparam int WORD_W = 32;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST    = 10'h000;
    localparam opcode_t OP_BYPASS    = 10'h3FF;
    localparam opcode_t OP_SAMPLE    = 10'h055;
    localparam opcode_t OP_IDCODE    = 10'h059;
    localparam opcode_t OP_USERCODE  = 10'h079;
    localparam opcode_t OP_INIT_CONF = 10'h061;
    localparam opcode_t OP_PEND_CONF = 10'h065;

    localparam logic [WORD_W-1:0] IDCODE_DEFAULT = 32'h0100_A0DD;
    localparam opcode_t IR_CAPTURE = opcode_t'(2'b01);

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDCODE, DR_USER, DR_BOUND
    } dr_sel_e;

    typedef struct packed {
        logic cap;
        logic sh;
        logic upd;
    } scan_ctl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e dr_select(opcode_t op);
        dr_sel_e d;
        case (op)
            OP_IDCODE:            d = DR_IDCODE;
            OP_USERCODE:          d = DR_USER;
            OP_SAMPLE, OP_EXTEST: d = DR_BOUND;
            default:              d = DR_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cfg_tap_fsm.sv
`timescale 1ns/1ps
module cfg_tap_fsm
    import cfg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e st,
    output scan_ctl_t  dr_ctl,
    output scan_ctl_t  ir_ctl,
    output logic       in_reset
);

    always_ff @(posedge tck) begin
        if (rst) st <= ST_TLR;
        else     st <= tap_next(st, tms);
    end

    always_comb begin
        dr_ctl.cap = (st == ST_CAP_DR);
        dr_ctl.sh  = (st == ST_SH_DR);
        dr_ctl.upd = (st == ST_UPD_DR);
        ir_ctl.cap = (st == ST_CAP_IR);
        ir_ctl.sh  = (st == ST_SH_IR);
        ir_ctl.upd = (st == ST_UPD_IR);
        in_reset   = (st == ST_TLR);
    end

endmodule

// File: rtl/cfg_tap_ireg.sv
`timescale 1ns/1ps
module cfg_tap_ireg
    import cfg_tap_pkg::*;
(
    input  logic      tck,
    input  logic      rst,
    input  logic      in_reset,
    input  scan_ctl_t ctl,
    input  logic      tdi,
    output opcode_t   ir_q,
    output logic      sr_lsb
);

    opcode_t sr;

    always_ff @(posedge tck) begin
        if (ctl.cap)     sr <= IR_CAPTURE;
        else if (ctl.sh) sr <= {tdi, sr[IR_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (rst || in_reset) ir_q <= OP_IDCODE;
        else if (ctl.upd)    ir_q <= sr;
    end

    assign sr_lsb = sr[0];

endmodule

// File: rtl/cfg_tap_bscan.sv
`timescale 1ns/1ps
module cfg_tap_bscan
    import cfg_tap_pkg::*;
#(
    parameter int LEN = 174
) (
    input  logic           tck,
    input  logic           rst,
    input  scan_ctl_t      ctl,
    input  logic           sel,
    input  logic           tdi,
    input  logic [LEN-1:0] pin_in,
    output logic           so,
    output logic [LEN-1:0] pin_out
);

    logic [LEN-1:0] chain;

    for (genvar j = 0; j < LEN; j++) begin : g_cell
        logic nxt;
        if (j == LEN - 1) begin : g_head
            assign nxt = tdi;
        end else begin : g_body
            assign nxt = chain[j+1];
        end

        always_ff @(posedge tck) begin
            if (sel && ctl.cap)     chain[j] <= pin_in[j];
            else if (sel && ctl.sh) chain[j] <= nxt;
        end

        always_ff @(posedge tck) begin
            if (rst)                 pin_out[j] <= 1'b0;
            else if (sel && ctl.upd) pin_out[j] <= chain[j];
        end
    end

    assign so = chain[0];

endmodule

// File: rtl/cfg_tap_recfg.sv
`timescale 1ns/1ps
module cfg_tap_recfg
    import cfg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e st,
    input  opcode_t    ir_q,
    output logic       recfg_low
);

    logic hold;
    logic is_pulse, is_pend;

    assign is_pulse = (ir_q == OP_INIT_CONF);
    assign is_pend  = (ir_q == OP_PEND_CONF);

    always_ff @(posedge tck) begin
        if (rst || st == ST_TLR) hold <= 1'b0;
        else if (is_pulse)       hold <= 1'b0;
        else if (is_pend)        hold <= 1'b1;
    end

    assign recfg_low = (hold && !is_pulse) || is_pend || (is_pulse && st == ST_RTI);

endmodule

// File: rtl/cfg_tap.sv
`timescale 1ns/1ps
module cfg_tap
    import cfg_tap_pkg::*;
#(
    parameter int                BSC_LEN    = 174,
    parameter logic [WORD_W-1:0] ID_VALUE   = IDCODE_DEFAULT,
    parameter logic [WORD_W-1:0] UCODE_INIT = 32'hFFFF_FFFF
) (
    input  logic               tck,
    input  logic               tap_rst,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic               ucode_load,
    input  logic [WORD_W-1:0]  ucode_value,
    input  logic [BSC_LEN-1:0] pin_in,
    output logic [BSC_LEN-1:0] pin_out,
    output logic               pin_drive,
    output logic               recfg_low
);

    tap_state_e        st;
    scan_ctl_t         dr_ctl, ir_ctl;
    logic              in_reset;
    opcode_t           ir_q;
    logic              ir_lsb;
    dr_sel_e           sel;
    logic [WORD_W-1:0] ucode_q;
    logic [WORD_W-1:0] word_sr;
    logic              word_sel;
    logic              byp_q;
    logic              bsc_so;
    logic              dr_lsb;

    cfg_tap_fsm u_fsm (
        .tck      (tck),
        .rst      (tap_rst),
        .tms      (tms),
        .st       (st),
        .dr_ctl   (dr_ctl),
        .ir_ctl   (ir_ctl),
        .in_reset (in_reset)
    );

    cfg_tap_ireg u_ireg (
        .tck      (tck),
        .rst      (tap_rst),
        .in_reset (in_reset),
        .ctl      (ir_ctl),
        .tdi      (tdi),
        .ir_q     (ir_q),
        .sr_lsb   (ir_lsb)
    );

    assign sel      = dr_select(ir_q);
    assign word_sel = (sel == DR_IDCODE) || (sel == DR_USER);

    always_ff @(posedge tck) begin
        if (tap_rst)         ucode_q <= UCODE_INIT;
        else if (ucode_load) ucode_q <= ucode_value;
    end

    always_ff @(posedge tck) begin
        if (word_sel && dr_ctl.cap)
            word_sr <= (sel == DR_IDCODE) ? ID_VALUE : ucode_q;
        else if (word_sel && dr_ctl.sh)
            word_sr <= {tdi, word_sr[WORD_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (sel == DR_BYPASS && dr_ctl.cap)     byp_q <= 1'b0;
        else if (sel == DR_BYPASS && dr_ctl.sh) byp_q <= tdi;
    end

    cfg_tap_bscan #(.LEN(BSC_LEN)) u_bscan (
        .tck     (tck),
        .rst     (tap_rst),
        .ctl     (dr_ctl),
        .sel     (sel == DR_BOUND),
        .tdi     (tdi),
        .pin_in  (pin_in),
        .so      (bsc_so),
        .pin_out (pin_out)
    );

    assign pin_drive = (ir_q == OP_EXTEST);

    cfg_tap_recfg u_recfg (
        .tck       (tck),
        .rst       (tap_rst),
        .st        (st),
        .ir_q      (ir_q),
        .recfg_low (recfg_low)
    );

    always_comb begin
        case (sel)
            DR_IDCODE, DR_USER: dr_lsb = word_sr[0];
            DR_BOUND:           dr_lsb = bsc_so;
            default:            dr_lsb = byp_q;
        endcase
    end

    always_ff @(negedge tck) begin
        tdo_oe <= (st == ST_SH_DR) || (st == ST_SH_IR);
        if (st == ST_SH_IR)      tdo <= ir_lsb;
        else if (st == ST_SH_DR) tdo <= dr_lsb;
    end

endmodule

// File: rtl/cfg_tap_chk.sv
`timescale 1ns/1ps
module cfg_tap_chk
    import cfg_tap_pkg::*;
#(
    parameter int LEN = 174
) (
    input logic           tck,
    input logic           rst,
    input logic           tms,
    input tap_state_e     st,
    input opcode_t        ir,
    input logic           tdo_oe,
    input logic           recfg_low,
    input logic [LEN-1:0] pin_out
);

    AST_TLR_AFTER_FIVE: assert property (@(posedge tck) disable iff (rst)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (st == ST_TLR)); // R1

    AST_IR_ONLY_UPDATE: assert property (@(posedge tck) disable iff (rst)
        !(st == ST_UPD_IR || st == ST_TLR) |=> $stable(ir)); // R2

    AST_PIN_OUT_HELD: assert property (@(posedge tck) disable iff (rst)
        (st != ST_UPD_DR) |=> $stable(pin_out)); // R6

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (st == ST_SH_DR || st == ST_SH_IR)); // R8

    AST_PULSE_IN_IDLE: assert property (@(posedge tck) disable iff (rst)
        (ir == OP_INIT_CONF) |-> (recfg_low == (st == ST_RTI))); // R9

    AST_HOLD_KEPT: assert property (@(posedge tck) disable iff (rst)
        (recfg_low && ir != OP_INIT_CONF && st != ST_TLR) |=> (recfg_low || ir == OP_INIT_CONF)); // R10

endmodule

bind cfg_tap cfg_tap_chk #(.LEN(BSC_LEN)) u_chk (
    .tck       (tck),
    .rst       (tap_rst),
    .tms       (tms),
    .st        (st),
    .ir        (ir_q),
    .tdo_oe    (tdo_oe),
    .recfg_low (recfg_low),
    .pin_out   (pin_out)
);

// File: tb/cfg_tap_bench.sv
`timescale 1ns/1ps
module cfg_tap_bench;

    localparam int L = 174;
    localparam logic [9:0] C_EXT  = 10'h000;
    localparam logic [9:0] C_BYP  = 10'h3FF;
    localparam logic [9:0] C_SMP  = 10'h055;
    localparam logic [9:0] C_IDC  = 10'h059;
    localparam logic [9:0] C_USR  = 10'h079;
    localparam logic [9:0] C_INIT = 10'h061;
    localparam logic [9:0] C_PEND = 10'h065;
    localparam logic [31:0] ID_EXP = 32'h0100A0DD;

    logic         tck = 1'b0;
    logic         tap_rst = 1'b1;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic         ucode_load = 1'b0;
    logic [31:0]  ucode_value = '0;
    logic [L-1:0] pin_in = '0;
    wire          tdo, tdo_oe, pin_drive, recfg_low;
    wire  [L-1:0] pin_out;

    int errors = 0;
    int checks = 0;
    int moved  = 0;
    logic oe_last, rf_last, oe_sh, rf_sh;
    logic [31:0]  ucode_m;
    logic [L-1:0] pin_exp;
    logic         hold_m;

    cfg_tap u_cfg_tap (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .ucode_load(ucode_load), .ucode_value(ucode_value), .pin_in(pin_in),
        .pin_out(pin_out), .pin_drive(pin_drive), .recfg_low(recfg_low)
    );

    always #2 tck = ~tck;

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m;
        tdi = d;
        #1;
        o = tdo;
        oe_last = tdo_oe;
        rf_last = recfg_low;
        @(posedge tck);
        #0.5;
        if (tdo !== o) moved++;
    endtask

    task automatic ir_scan(input logic [9:0] op, output logic [9:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 10; i++) begin
            step(i == 9, op[i], o);
            cap[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic dr_scan(input int n, input logic [255:0] din, output logic [255:0] dout);
        logic o;
        dout = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
            if (i == 0) begin
                oe_sh = oe_last;
                rf_sh = rf_last;
            end
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic idle_sample(output logic rf, output logic oe);
        @(negedge tck);
        #1;
        rf = recfg_low;
        oe = tdo_oe;
    endtask

    task automatic do_reset();
        logic o;
        @(negedge tck);
        tap_rst = 1'b1;
        tms = 1'b1;
        repeat (3) @(negedge tck);
        tap_rst = 1'b0;
        step(0, 0, o);
        hold_m  = 1'b0;
        pin_exp = '0;
        ucode_m = 32'hFFFF_FFFF;
    endtask

    function automatic int op_len(logic [9:0] op);
        if (op == C_IDC || op == C_USR) return 32;
        if (op == C_SMP || op == C_EXT) return L;
        return 1;
    endfunction

    function automatic logic [255:0] op_cap(logic [9:0] op);
        if (op == C_IDC) return 256'(ID_EXP);
        if (op == C_USR) return 256'(ucode_m);
        if (op == C_SMP || op == C_EXT) return 256'(pin_in);
        return '0;
    endfunction

    function automatic logic [255:0] exp_scan(int len, logic [255:0] cap, logic [255:0] din, int n);
        logic [255:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : din[i - len];
        return r;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [9:0]   icap;
        logic [255:0] dout, din;
        logic         rf, oe, o;
        int           n, len;
        logic [9:0]   op;
        void'($urandom(32'd4242));

        repeat (3) @(negedge tck);
        #1;
        chk("R1 reset tdo_oe", 256'(tdo_oe), 0);
        chk("R1 reset recfg_low", 256'(recfg_low), 0);
        chk("R1 reset pin_drive", 256'(pin_drive), 0);
        chk("R1 reset pin_out", 256'(pin_out), 0);
        do_reset();

        // R2 R4: identification word is the default data register after reset
        dr_scan(40, 256'h0, dout);
        chk("R4 idcode after reset", dout, 256'(ID_EXP));
        chk("R8 tdo_oe in Shift-DR", 256'(oe_sh), 1);
        idle_sample(rf, oe);
        chk("R8 tdo_oe idle", 256'(oe), 0);

        // R3 bypass: one-bit delay, captures 0
        ir_scan(C_BYP, icap);
        chk("R2 ir capture", 256'(icap), 256'h001);
        din = 256'hA5;
        dr_scan(8, din, dout);
        chk("R3 bypass delay", dout, exp_scan(1, 0, din, 8));

        // R5 user word loaded, read twice
        @(negedge tck);
        ucode_value = 32'h1234_5678;
        ucode_load = 1'b1;
        @(negedge tck);
        ucode_load = 1'b0;
        ucode_m = 32'h1234_5678;
        ir_scan(C_USR, icap);
        din = 256'hFFFF_FFFF;
        dr_scan(32, din, dout);
        chk("R5 usercode read", dout, 256'h1234_5678);
        dr_scan(32, 256'h0, dout);
        chk("R5 usercode kept after shift", dout, 256'h1234_5678);

        // R9 pulse only in Run-Test/Idle
        ir_scan(C_INIT, icap);
        for (int k = 0; k < 3; k++) begin
            idle_sample(rf, oe);
            chk("R9 low while idle", 256'(rf), 1);
        end
        dr_scan(4, 256'h0, dout);
        chk("R9 released outside idle", 256'(rf_sh), 0);

        // R10 hold across instructions, released by pulse instruction
        ir_scan(C_PEND, icap);
        idle_sample(rf, oe);
        chk("R10 hold set", 256'(rf), 1);
        ir_scan(C_BYP, icap);
        dr_scan(4, 256'h0, dout);
        chk("R10 hold through bypass", 256'(rf_sh), 1);
        ir_scan(C_IDC, icap);
        dr_scan(32, 256'h0, dout);
        chk("R10 hold through idcode", 256'(rf_sh), 1);
        ir_scan(C_INIT, icap);
        dr_scan(4, 256'h0, dout);
        chk("R10 released by pulse instr", 256'(rf_sh), 0);

        // R1 R10: five TMS ones from Shift-DR clear the hold and reload identify
        ir_scan(C_PEND, icap);
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int k = 0; k < 5; k++) step(1, 0, o);
        step(0, 0, o);
        idle_sample(rf, oe);
        chk("R1 tms reset clears hold", 256'(rf), 0);
        dr_scan(32, 256'h0, dout);
        chk("R2 identify reloaded after tms reset", dout, 256'(ID_EXP));

        // R1 test reset input clears hold
        ir_scan(C_PEND, icap);
        do_reset();
        idle_sample(rf, oe);
        chk("R1 tap_rst clears hold", 256'(rf), 0);

        // R6 R7 external test
        pin_in = L'(rnd256());
        ir_scan(C_EXT, icap);
        idle_sample(rf, oe);
        chk("R7 drive under extest", 256'(pin_drive), 1);
        din = rnd256();
        dr_scan(L, din, dout);
        chk("R6 extest capture", dout, 256'(pin_in));
        chk("R6 extest update", 256'(pin_out), 256'(L'(din)));
        pin_exp = L'(din);
        ir_scan(C_SMP, icap);
        chk("R7 no drive under sample", 256'(pin_drive), 0);
        chk("R6 pin_out held across ir", 256'(pin_out), 256'(pin_exp));

        // random mix
        for (int it = 0; it < 40; it++) begin
            case ($urandom % 9)
                0: op = C_EXT;  1: op = C_BYP;  2: op = C_SMP;
                3: op = C_IDC;  4: op = C_USR;  5: op = C_INIT;
                6: op = C_PEND; default: op = 10'($urandom);
            endcase
            if ($urandom % 2 == 1) begin
                @(negedge tck);
                ucode_value = $urandom;
                ucode_load = 1'b1;
                ucode_m = ucode_value;
                @(negedge tck);
                ucode_load = 1'b0;
            end
            ir_scan(op, icap);
            chk("R2 ir capture random", 256'(icap), 256'h001);
            if (op == C_PEND) hold_m = 1'b1;
            else if (op == C_INIT) hold_m = 1'b0;
            idle_sample(rf, oe);
            chk("R9 R10 idle recfg", 256'(rf), 256'((op == C_INIT) || (op == C_PEND) || hold_m));
            chk("R7 pin_drive", 256'(pin_drive), 256'(op == C_EXT));
            @(negedge tck);
            pin_in = L'(rnd256());
            len = op_len(op);
            n = len + 8;
            din = rnd256();
            dr_scan(n, din, dout);
            chk("R3 R4 R5 R6 dr scan", dout, exp_scan(len, op_cap(op), din, n));
            chk("R9 R10 shift recfg", 256'(rf_sh), 256'((op == C_PEND) || (hold_m && op != C_INIT)));
            if (len == L) pin_exp = L'(din >> (n - L));
            chk("R6 pin_out", 256'(pin_out), 256'(pin_exp));
        end

        chk("R8 tdo stable at rising edge", moved, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule